// File: doc/BRIEF.md
# Dual-Port Associative Shared-Variable Store

This block is a small fully associative store that holds variables shared between processing cores. A producer writes a variable through a dedicated write port, and a consumer looks it up through a separate read port. The two ports never compete, so a write and a read can both be accepted in the same clock cycle. Each line holds a key and a data word. The key is made of a 12-bit variable address and a 4-bit version number. Each line also has an occupancy flag, which is kept as the top bit of the stored tag.

The write side does not decide where data goes. An external allocator supplies the line index for every write, so the choice of victim line stays outside this block. On the read side, the search key is compared against every occupied line in parallel. The block returns a hit flag, the matching line index and the data word, all registered, so the result appears one cycle after the request. A release input frees one chosen line by clearing its occupancy flag, which lets the allocator see that the line can be reused.

Top module: `shvar_cam_store`

## Requirements
- R1: After reset every line is free. A lookup issued before any write reports a miss, and `lk_valid`, `lk_hit`, `lk_line` and `lk_data` are all zero while reset is applied.
- R2: A write to line L with key (A, V) and data D makes that entry visible to lookups issued from the next cycle on. A lookup issued in cycle t drives its result on the outputs after the clock edge that ends cycle t.
- R3: A lookup hits a line only when the line is occupied and both the 12-bit address and the 4-bit version are equal to the search key. A difference in either field gives a miss.
- R4: A lookup and a write in the same cycle see the store as it was before that write. If the written key was absent, the lookup misses. If the key was already held in another line, the lookup returns that line's old contents.
- R5: When several occupied lines match the search key, the lowest line index is returned together with its data.
- R6: A release of line L clears only that line's occupancy. Lookups of L's key miss afterwards, and every other line still hits as before.
- R7: A write and a release that target the same line in the same cycle leave the line occupied, holding the newly written key and data.
- R8: Writing a new key into an occupied line replaces the old entry. The old key then misses unless another line holds it.
- R9: `lk_valid` is high exactly in the cycle after a lookup request. `lk_hit` is never high without `lk_valid`. A miss returns line 0 and data 0. In cycles with no request, `lk_line` and `lk_data` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_en | input | 1 | Store request |
| st_line | input | $clog2(LINES) | Line index chosen by the allocator |
| st_addr | input | 12 | Address field of the stored key |
| st_ver | input | 4 | Version field of the stored key |
| st_data | input | DATA_W | Data word to store |
| free_en | input | 1 | Release request |
| free_line | input | $clog2(LINES) | Line whose occupancy is cleared |
| lk_en | input | 1 | Lookup request |
| lk_addr | input | 12 | Address field of the search key |
| lk_ver | input | 4 | Version field of the search key |
| lk_valid | output | 1 | Lookup result present (registered) |
| lk_hit | output | 1 | Lookup found a matching occupied line |
| lk_line | output | $clog2(LINES) | Index of the matching line |
| lk_data | output | DATA_W | Data of the matching line |

## Verification
The hardest situations to reach are the ones where several things collide in one cycle. One is a lookup that races a write of the same key while another line already holds that key. Another is a write and a release aimed at the same line. A third is a store where two lines hold the same key. The stimulus builds each of these on purpose. It first fills every line with a distinct key. It then writes duplicate keys into both higher and lower lines than the existing copy. Finally it issues the racing lookup or release in the same cycle as the write. A line-by-line reference model in the bench predicts the result before each clock edge.

// File: rtl/shvar_cam_pkg.sv
package shvar_cam_pkg;

    localparam int KEY_ADDR_W = 12;
    localparam int KEY_VER_W  = 4;
    localparam int KEY_W      = KEY_ADDR_W + KEY_VER_W;
    localparam int TAG_W      = KEY_W + 1;   // occupancy flag is the top bit

    typedef struct packed {
        logic [KEY_ADDR_W-1:0] addr;
        logic [KEY_VER_W-1:0]  ver;
    } cam_key_t;

    typedef struct packed {
        logic     occ;
        cam_key_t key;
    } cam_tag_t;

    function automatic cam_key_t make_key(input logic [KEY_ADDR_W-1:0] a,
                                          input logic [KEY_VER_W-1:0]  v);
        cam_key_t k;
        k.addr = a;
        k.ver  = v;
        return k;
    endfunction

    function automatic logic key_hit(input cam_tag_t t, input cam_key_t k);
        return t.occ && (t.key.addr == k.addr) && (t.key.ver == k.ver);
    endfunction

endpackage

// File: rtl/shvar_cam_lines.sv
module shvar_cam_lines
    import shvar_cam_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          st_en,
    input  logic [IDX_W-1:0]              st_line,
    input  cam_key_t                      st_key,
    input  logic [DATA_W-1:0]             st_data,
    input  logic                          free_en,
    input  logic [IDX_W-1:0]              free_line,
    output cam_tag_t [LINES-1:0]          tags_o,
    output logic [LINES-1:0][DATA_W-1:0]  data_o
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic sel_st;
        logic sel_free;

        assign sel_st   = st_en   && (st_line   == IDX_W'(i));
        assign sel_free = free_en && (free_line == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                tags_o[i] <= '0;
                data_o[i] <= '0;
            end else if (sel_st) begin
                // a store to this line takes precedence over a release
                tags_o[i].occ <= 1'b1;
                tags_o[i].key <= st_key;
                data_o[i]     <= st_data;
            end else if (sel_free) begin
                tags_o[i].occ <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/shvar_cam_match.sv
module shvar_cam_match
    import shvar_cam_pkg::*;
#(
    parameter int LINES = 16
) (
    input  cam_tag_t [LINES-1:0] tags,
    input  cam_key_t             search,
    output logic [LINES-1:0]     match
);

    for (genvar i = 0; i < LINES; i++) begin : g_cmp
        assign match[i] = key_hit(tags[i], search);
    end

endmodule

// File: rtl/shvar_cam_prio.sv
module shvar_cam_prio #(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] match,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        // scan downward so the lowest set bit is written last
        for (int i = LINES - 1; i >= 0; i--) begin
            if (match[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/shvar_cam_store.sv
module shvar_cam_store
    import shvar_cam_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_en,
    input  logic [IDX_W-1:0]      st_line,
    input  logic [KEY_ADDR_W-1:0] st_addr,
    input  logic [KEY_VER_W-1:0]  st_ver,
    input  logic [DATA_W-1:0]     st_data,
    input  logic                  free_en,
    input  logic [IDX_W-1:0]      free_line,
    input  logic                  lk_en,
    input  logic [KEY_ADDR_W-1:0] lk_addr,
    input  logic [KEY_VER_W-1:0]  lk_ver,
    output logic                  lk_valid,
    output logic                  lk_hit,
    output logic [IDX_W-1:0]      lk_line,
    output logic [DATA_W-1:0]     lk_data
);

    cam_tag_t [LINES-1:0]         tags;
    logic [LINES-1:0][DATA_W-1:0] words;
    logic [LINES-1:0]             match;
    logic [LINES-1:0]             occ_q;
    logic                         found;
    logic [IDX_W-1:0]             hit_idx;

    for (genvar i = 0; i < LINES; i++) begin : g_occ
        assign occ_q[i] = tags[i].occ;
    end

    shvar_cam_lines #(.LINES(LINES), .DATA_W(DATA_W)) lines_i (
        .clk       (clk),
        .rst       (rst),
        .st_en     (st_en),
        .st_line   (st_line),
        .st_key    (make_key(st_addr, st_ver)),
        .st_data   (st_data),
        .free_en   (free_en),
        .free_line (free_line),
        .tags_o    (tags),
        .data_o    (words)
    );

    shvar_cam_match #(.LINES(LINES)) match_i (
        .tags   (tags),
        .search (make_key(lk_addr, lk_ver)),
        .match  (match)
    );

    shvar_cam_prio #(.LINES(LINES)) prio_i (
        .match (match),
        .found (found),
        .idx   (hit_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_valid <= 1'b0;
            lk_hit   <= 1'b0;
            lk_line  <= '0;
            lk_data  <= '0;
        end else begin
            lk_valid <= lk_en;
            lk_hit   <= lk_en && found;
            if (lk_en) begin
                lk_line <= found ? hit_idx : '0;
                lk_data <= found ? words[hit_idx] : '0;
            end
        end
    end

endmodule

// File: rtl/shvar_cam_checker.sv
module shvar_cam_checker #(
    parameter int LINES  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst,
    input logic              st_en,
    input logic [IDX_W-1:0]  st_line,
    input logic              free_en,
    input logic [IDX_W-1:0]  free_line,
    input logic              lk_en,
    input logic              lk_valid,
    input logic              lk_hit,
    input logic [DATA_W-1:0] lk_data,
    input logic [LINES-1:0]  occ
);

    assert_first_result_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit && !lk_valid);

    assert_result_latency_R2: assert property (@(posedge clk) disable iff (rst)
        lk_en |=> lk_valid);

    assert_no_spurious_result_R9: assert property (@(posedge clk) disable iff (rst)
        !lk_en |=> !lk_valid);

    assert_hit_implies_valid_R9: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_valid);

    assert_miss_zero_data_R9: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_hit) |-> (lk_data == '0));

    assert_release_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (free_en && !(st_en && st_line == free_line)) |=> !occ[$past(free_line)]);

    assert_store_wins_R7: assert property (@(posedge clk) disable iff (rst)
        st_en |=> occ[$past(st_line)]);

endmodule

bind shvar_cam_store shvar_cam_checker #(.LINES(LINES), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .st_en     (st_en),
    .st_line   (st_line),
    .free_en   (free_en),
    .free_line (free_line),
    .lk_en     (lk_en),
    .lk_valid  (lk_valid),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data),
    .occ       (occ_q)
);

// File: tb/shvar_cam_store_tb_top.sv
module shvar_cam_store_tb_top;

    localparam int LINES  = 16;
    localparam int DATA_W = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_en = 1'b0;
    logic [3:0]  st_line = '0;
    logic [11:0] st_addr = '0;
    logic [3:0]  st_ver = '0;
    logic [31:0] st_data = '0;
    logic        free_en = 1'b0;
    logic [3:0]  free_line = '0;
    logic        lk_en = 1'b0;
    logic [11:0] lk_addr = '0;
    logic [3:0]  lk_ver = '0;
    logic        lk_valid;
    logic        lk_hit;
    logic [3:0]  lk_line;
    logic [31:0] lk_data;

    int errors = 0;
    int checks = 0;

    bit          m_occ  [LINES];
    int          m_addr [LINES];
    int          m_ver  [LINES];
    logic [31:0] m_data [LINES];
    logic [3:0]  e_line = '0;
    logic [31:0] e_data = '0;

    always #4 clk = ~clk;   // 125 MHz

    shvar_cam_store #(.LINES(LINES), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst),
        .st_en(st_en), .st_line(st_line), .st_addr(st_addr), .st_ver(st_ver), .st_data(st_data),
        .free_en(free_en), .free_line(free_line),
        .lk_en(lk_en), .lk_addr(lk_addr), .lk_ver(lk_ver),
        .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_line(lk_line), .lk_data(lk_data)
    );

    function automatic logic [31:0] pat(input int i);
        return 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0107);
    endfunction

    // one cycle: expected lookup result is taken from the model before its update
    task automatic step(input string req,
                        input bit we, input int wl, input int wa, input int wv, input logic [31:0] wd,
                        input bit fe, input int fl,
                        input bit le, input int la, input int lv);
        bit e_hit = 1'b0;
        if (le) begin
            e_line = '0;
            e_data = '0;
            for (int i = 0; i < LINES; i++) begin
                if (!e_hit && m_occ[i] && m_addr[i] == la && m_ver[i] == lv) begin
                    e_hit  = 1'b1;
                    e_line = 4'(i);
                    e_data = m_data[i];
                end
            end
        end
        @(negedge clk);
        st_en = we; st_line = 4'(wl); st_addr = 12'(wa); st_ver = 4'(wv); st_data = wd;
        free_en = fe; free_line = 4'(fl);
        lk_en = le; lk_addr = 12'(la); lk_ver = 4'(lv);
        @(posedge clk);
        #1;
        checks++;
        if (lk_valid !== le || lk_hit !== e_hit || lk_line !== e_line || lk_data !== e_data) begin
            errors++;
            $display("FAIL %s: valid=%0b hit=%0b line=%0d data=%h expected valid=%0b hit=%0b line=%0d data=%h",
                     req, lk_valid, lk_hit, lk_line, lk_data, le, e_hit, e_line, e_data);
        end
        if (fe) m_occ[fl] = 1'b0;
        if (we) begin
            m_occ[wl]  = 1'b1;
            m_addr[wl] = wa;
            m_ver[wl]  = wv;
            m_data[wl] = wd;
        end
    endtask

    task automatic rd(input string req, input int la, input int lv);
        step(req, 0, 0, 0, 0, 0, 0, 0, 1, la, lv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin
            m_occ[i] = 0; m_addr[i] = 0; m_ver[i] = 0; m_data[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (lk_valid !== 1'b0 || lk_hit !== 1'b0 || lk_line !== '0 || lk_data !== '0) begin
            errors++;
            $display("FAIL R1: valid=%0b hit=%0b line=%0d data=%h expected all zero",
                     lk_valid, lk_hit, lk_line, lk_data);
        end
        @(negedge clk);
        rst = 1'b0;

        // R1: empty store misses everywhere
        for (int i = 0; i < LINES; i++) rd("R1", i * 37 + 5, i % 16);
        rd("R1", 0, 0);

        // R4: fill all lines, each with a same-cycle lookup of the key being written
        for (int i = 0; i < LINES; i++)
            step("R4", 1, i, i * 37 + 5, i % 16, pat(i), 0, 0, 1, i * 37 + 5, i % 16);

        // R2: every stored entry is visible next cycle
        for (int i = 0; i < LINES; i++) rd("R2", i * 37 + 5, i % 16);

        // R3: version or address mismatch misses
        for (int i = 0; i < LINES; i++) begin
            rd("R3", i * 37 + 5, (i + 1) % 16);
            rd("R3", (i * 37 + 5) ^ 12'h800, i % 16);
        end

        // R9: idle cycles keep line/data, valid and hit low
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R5: duplicate key of line 3 put in line 15, lowest index wins
        step("R5", 1, 15, 3 * 37 + 5, 3, 32'hDEAD_0015, 0, 0, 1, 3 * 37 + 5, 3);
        rd("R5", 3 * 37 + 5, 3);

        // R6: release line 3, copy in line 15 now answers
        step("R6", 0, 0, 0, 0, 0, 1, 3, 0, 0, 0);
        rd("R6", 3 * 37 + 5, 3);

        // R7: store and release of line 3 in one cycle
        step("R7", 1, 3, 12'h7AB, 9, 32'h7777_0003, 1, 3, 0, 0, 0);
        rd("R7", 12'h7AB, 9);

        // R6: release even lines, check all lines
        for (int i = 0; i < LINES; i += 2) step("R6", 0, 0, 0, 0, 0, 1, i, 0, 0, 0);
        for (int i = 0; i < LINES; i++) rd("R6", i * 37 + 5, i % 16);
        rd("R6", 12'h7AB, 9);

        // R8: overwrite line 1, old key gone, new key present
        step("R8", 1, 1, 12'h123, 4, 32'h0BAD_F00D, 0, 0, 0, 0, 0);
        rd("R8", 1 * 37 + 5, 1);
        rd("R8", 12'h123, 4);

        // R4: key held in line 5, same key written to line 0 with a racing lookup
        step("R4", 1, 0, 5 * 37 + 5, 5, 32'h1234_5678, 0, 0, 1, 5 * 37 + 5, 5);
        rd("R5", 5 * 37 + 5, 5);

        // R9: idle after a hit, then a miss
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rd("R9", 12'hFFF, 15);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule